// File: doc/BRIEF.md
# Host Pixel Packer with Windowed Address Counters

This block sits between a host data bus and the display memory of a grayscale panel controller. It takes display-data strobes, which are bytes sent while the register-select input is high. It splits each byte into 4-bit pixels according to a 2-bit packing format and collects eight pixels into a 32-bit word. When the word is full, it issues one write on a synchronous RAM port. A column counter counts in 8-pixel words and a row counter counts in lines. Together they give the RAM address. They step through a rectangular window whose bounds are programmable.

The block also serves host reads. The first read of a sequence returns a dummy value and starts a fetch from RAM. Each later read returns two pixels of the fetched word. A small register port sets the window bounds, the packing format, the auto-increment enable and the two address counters. Bus-protocol decoding and the RAM array itself lie outside the block.

Top module: `hpx_packer`

## Requirements
- R1: After reset the window is columns 0..19 and rows 0..159. The format is 1, auto-increment is on, both counters are 0 and `host_dout` is 8'h00. The register map is: 0 column start, 1 column end, 2 row start, 3 row end, 4 mode, 5 column counter, 6 row counter. The mode register holds the format in bits [1:0] and the auto-increment enable in bit 2.
- R2: Pixel k of a word (k = 0..7, in order of arrival) sits in RAM bits [4k+3:4k]. In format 0 each byte carries two pixels, the high nibble first and the low nibble second.
- R3: Format 1 also carries two pixels per byte, but the low nibble comes first. In formats 0 and 1 exactly one RAM write is issued after every fourth data strobe, one cycle after that strobe.
- R4: Formats 2 and 3 carry one pixel per byte: the high nibble in format 2 and the low nibble in format 3. The other nibble has no effect. One RAM write is issued after every eighth strobe.
- R5: The RAM address is row*20 + column. When auto-increment is on, the column counter advances by one after each RAM word that is written or fully read.
- R6: When the column counter steps past the column end, it returns to the column start and the row counter advances. When the row counter steps past the row end, it returns to the row start.
- R7: When auto-increment is off, the counters never step, so successive words use the same address.
- R8: Writing the column or row counter register sets that counter. The register write, and a write of the mode register, both discard any partly collected pixels.
- R9: The first host read after any pixel write or register write returns 8'h00 and starts a RAM fetch. Each later read returns two pixels, the earlier one in the high nibble. Every fourth such read moves on to the next word.
- R10: A host strobe with register-select low has no effect on the pixels or on the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write pulse |
| reg_sel | input | 3 | Register index |
| reg_din | input | 8 | Register write value |
| host_wr | input | 1 | Host write strobe, one cycle |
| host_rd | input | 1 | Host read strobe, one cycle |
| host_rs | input | 1 | Register select, 1 = display data |
| host_din | input | 8 | Host write byte |
| host_dout | output | 8 | Host read byte |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_addr | output | 12 | RAM word address |
| ram_wdata | output | 32 | RAM write word |
| ram_rdata | input | 32 | RAM read word, valid the cycle after `ram_re` |

## Verification
A wrong pixel count or a stale accumulator shows up at the latest one strobe later. It appears as a RAM write that comes early or late, or as a word whose nibbles are mixed with older data. A counter that steps wrongly or wraps wrongly is seen on the very next RAM write, as an unexpected `ram_addr`. The bench therefore checks every write's address as well as its data. A read-side sequencing fault appears in the first byte after the dummy read or at the word boundary four reads later. For that reason the read test crosses two words.

// File: rtl/hpx_pkg.sv
package hpx_pkg;
  localparam int PIX_W    = 4;
  localparam int WORD_PIX = 8;
  localparam int WORD_W   = PIX_W * WORD_PIX;

  localparam logic [2:0] RA_XLO  = 3'd0;
  localparam logic [2:0] RA_XHI  = 3'd1;
  localparam logic [2:0] RA_YLO  = 3'd2;
  localparam logic [2:0] RA_YHI  = 3'd3;
  localparam logic [2:0] RA_MODE = 3'd4;
  localparam logic [2:0] RA_COL  = 3'd5;
  localparam logic [2:0] RA_ROW  = 3'd6;

  typedef logic [WORD_PIX-1:0][PIX_W-1:0] word_t;

  // format 1 and 3 take the low nibble as the (first) pixel
  function automatic logic [PIX_W-1:0] lead_pix(input logic [1:0] fmt, input logic [7:0] b);
    return fmt[0] ? b[3:0] : b[7:4];
  endfunction

  function automatic logic [PIX_W-1:0] trail_pix(input logic [1:0] fmt, input logic [7:0] b);
    return fmt[0] ? b[7:4] : b[3:0];
  endfunction

  function automatic logic two_per_byte(input logic [1:0] fmt);
    return !fmt[1];
  endfunction
endpackage

// File: rtl/hpx_cfg.sv
module hpx_cfg #(
  parameter int COL_W   = 5,
  parameter int ROW_W   = 8,
  parameter int XHI_DEF = 19,
  parameter int YHI_DEF = 159
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_sel,
  input  logic [7:0]       reg_din,
  output logic [COL_W-1:0] xlo,
  output logic [COL_W-1:0] xhi,
  output logic [ROW_W-1:0] ylo,
  output logic [ROW_W-1:0] yhi,
  output logic [1:0]       fmt,
  output logic             auto_inc,
  output logic             col_ld,
  output logic             row_ld,
  output logic             clr_acc
);
  import hpx_pkg::*;

  assign col_ld  = reg_wr && (reg_sel == RA_COL);
  assign row_ld  = reg_wr && (reg_sel == RA_ROW);
  assign clr_acc = col_ld || row_ld || (reg_wr && reg_sel == RA_MODE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xlo      <= '0;
      xhi      <= COL_W'(XHI_DEF);
      ylo      <= '0;
      yhi      <= ROW_W'(YHI_DEF);
      fmt      <= 2'd1;
      auto_inc <= 1'b1;
    end else if (reg_wr) begin
      case (reg_sel)
        RA_XLO:  xlo <= reg_din[COL_W-1:0];
        RA_XHI:  xhi <= reg_din[COL_W-1:0];
        RA_YLO:  ylo <= reg_din[ROW_W-1:0];
        RA_YHI:  yhi <= reg_din[ROW_W-1:0];
        RA_MODE: begin
          fmt      <= reg_din[1:0];
          auto_inc <= reg_din[2];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/hpx_addr_ctr.sv
module hpx_addr_ctr #(
  parameter int COL_W = 5,
  parameter int ROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [COL_W-1:0] xlo,
  input  logic [COL_W-1:0] xhi,
  input  logic [ROW_W-1:0] ylo,
  input  logic [ROW_W-1:0] yhi,
  input  logic             step,
  input  logic             col_ld,
  input  logic             row_ld,
  input  logic [7:0]       ld_val,
  output logic [COL_W-1:0] col,
  output logic [ROW_W-1:0] row
);
  logic [COL_W-1:0] col_n;
  logic [ROW_W-1:0] row_n;
  logic             col_wrap;
  logic             row_wrap;

  assign col_wrap = step && (col == xhi);
  assign row_wrap = col_wrap && (row == yhi);

  always_comb begin
    col_n = col;
    row_n = row;
    if (step) begin
      if (col_wrap) begin
        col_n = xlo;
        row_n = row_wrap ? ylo : row + ROW_W'(1);
      end else begin
        col_n = col + COL_W'(1);
      end
    end
    if (col_ld && (ld_val[COL_W-1:0] != col)) col_n = ld_val[COL_W-1:0];
    if (row_ld && (ld_val[ROW_W-1:0] != row)) row_n = ld_val[ROW_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
    end else begin
      col <= col_n;
      row <= row_n;
    end
  end

  AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !col_ld && !col_wrap) |=> (col == $past(col) + COL_W'(1))); // R5
  AST_COL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (col_wrap && !col_ld) |=> (col == $past(xlo))); // R6
  AST_ROW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (row_wrap && !row_ld) |=> (row == $past(ylo))); // R6
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !col_ld && !row_ld) |=> ($stable(col) && $stable(row))); // R7
endmodule

// File: rtl/hpx_wr_pack.sv
module hpx_wr_pack (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strobe,
  input  logic [7:0]            din,
  input  logic [1:0]            fmt,
  input  logic                  clr,
  output logic                  word_done,
  output hpx_pkg::word_t        word
);
  import hpx_pkg::*;

  word_t      acc;
  logic [2:0] cnt;
  logic       pair;
  logic [3:0] p_lead;
  logic [3:0] p_trail;

  assign pair    = two_per_byte(fmt);
  assign p_lead  = lead_pix(fmt, din);
  assign p_trail = trail_pix(fmt, din);

  always_comb begin
    word = acc;
    for (int k = 0; k < WORD_PIX; k++) begin
      if (k[2:0] == cnt)                    word[k] = p_lead;
      if (pair && (k[2:0] == cnt + 3'd1))   word[k] = p_trail;
    end
  end

  assign word_done = strobe && (pair ? (cnt == 3'd6) : (cnt == 3'd7));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
      acc <= '0;
    end else if (strobe) begin
      acc <= word;
      cnt <= word_done ? 3'd0 : cnt + (pair ? 3'd2 : 3'd1);
    end
  end

  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !clr) |=> (cnt == 3'd0)); // R3
  AST_PAIR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && pair) |-> !cnt[0]); // R2
endmodule

// File: rtl/hpx_rd_unpack.sv
module hpx_rd_unpack (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_strobe,
  input  logic        abort,
  input  logic [31:0] rdata,
  output logic        fetch,
  output logic        adv,
  output logic [7:0]  dout
);
  import hpx_pkg::*;

  logic       primed;
  logic [1:0] idx;
  logic       fetch_req;
  logic       f1;
  logic       f2;
  word_t      cur;

  assign fetch = fetch_req;
  assign adv   = rd_strobe && !abort && primed && (idx == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      idx       <= '0;
      fetch_req <= 1'b0;
      f1        <= 1'b0;
      f2        <= 1'b0;
      cur       <= '0;
      dout      <= '0;
    end else begin
      fetch_req <= 1'b0;
      f1        <= fetch_req;
      f2        <= f1;
      if (f2) cur <= rdata;
      if (abort) begin
        primed <= 1'b0;
      end else if (rd_strobe) begin
        if (!primed) begin
          primed    <= 1'b1;
          idx       <= '0;
          fetch_req <= 1'b1;
          dout      <= 8'h00;
        end else begin
          dout <= {cur[{idx, 1'b0}], cur[{idx, 1'b1}]};
          idx  <= idx + 2'd1;
          if (idx == 2'd3) fetch_req <= 1'b1;
        end
      end
    end
  end

  AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !abort && !primed) |=> (dout == 8'h00)); // R9
  AST_ADV_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> fetch); // R9
endmodule

// File: rtl/hpx_packer.sv
module hpx_packer #(
  parameter int PANEL_COLS = 160,
  parameter int PANEL_ROWS = 160
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_sel,
  input  logic [7:0]  reg_din,
  input  logic        host_wr,
  input  logic        host_rd,
  input  logic        host_rs,
  input  logic [7:0]  host_din,
  output logic [7:0]  host_dout,
  output logic        ram_we,
  output logic        ram_re,
  output logic [11:0] ram_addr,
  output logic [31:0] ram_wdata,
  input  logic [31:0] ram_rdata
);
  import hpx_pkg::*;

  localparam int WORDS_PER_ROW = PANEL_COLS / WORD_PIX;
  localparam int COL_W  = $clog2(WORDS_PER_ROW);
  localparam int ROW_W  = $clog2(PANEL_ROWS);
  localparam int ADDR_W = 12;

  function automatic logic [ADDR_W-1:0] word_addr(input logic [COL_W-1:0] c, input logic [ROW_W-1:0] r);
    return ADDR_W'(r) * ADDR_W'(WORDS_PER_ROW) + ADDR_W'(c);
  endfunction

  logic [COL_W-1:0] xlo, xhi, col;
  logic [ROW_W-1:0] ylo, yhi, row;
  logic [1:0]       fmt;
  logic             auto_inc, col_ld, row_ld, clr_acc;
  logic             pix_wr, pix_rd, word_done, fetch, adv, step;
  word_t            word;

  assign pix_wr = host_wr && host_rs && !reg_wr;
  assign pix_rd = host_rd && host_rs && !reg_wr;
  assign step   = auto_inc && (word_done || adv);

  hpx_cfg #(.COL_W(COL_W), .ROW_W(ROW_W), .XHI_DEF(WORDS_PER_ROW - 1), .YHI_DEF(PANEL_ROWS - 1)) u_cfg (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_din(reg_din),
    .xlo(xlo), .xhi(xhi), .ylo(ylo), .yhi(yhi), .fmt(fmt), .auto_inc(auto_inc),
    .col_ld(col_ld), .row_ld(row_ld), .clr_acc(clr_acc)
  );

  hpx_addr_ctr #(.COL_W(COL_W), .ROW_W(ROW_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .xlo(xlo), .xhi(xhi), .ylo(ylo), .yhi(yhi),
    .step(step), .col_ld(col_ld), .row_ld(row_ld), .ld_val(reg_din),
    .col(col), .row(row)
  );

  hpx_wr_pack u_pack (
    .clk(clk), .rst_n(rst_n), .strobe(pix_wr), .din(host_din), .fmt(fmt),
    .clr(clr_acc), .word_done(word_done), .word(word)
  );

  hpx_rd_unpack u_rd (
    .clk(clk), .rst_n(rst_n), .rd_strobe(pix_rd), .abort(pix_wr || reg_wr),
    .rdata(ram_rdata), .fetch(fetch), .adv(adv), .dout(host_dout)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_we    <= 1'b0;
      ram_re    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= word_done;
      ram_re <= fetch;
      if (word_done || fetch) ram_addr  <= word_addr(col, row);
      if (word_done)          ram_wdata <= word;
    end
  end

  AST_WE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> $past(host_wr && host_rs)); // R3
  AST_NO_STEP_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_inc |-> !step); // R7
endmodule

// File: tb/hpx_packer_tb.sv
module hpx_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [7:0]  reg_din = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_rs = 1'b0;
  logic [7:0]  host_din = '0;
  logic [7:0]  host_dout;
  logic        ram_we, ram_re;
  logic [11:0] ram_addr;
  logic [31:0] ram_wdata;
  logic [31:0] ram_rdata = '0;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [11:0] last_addr = '0;
  logic [31:0] last_data = '0;
  logic [31:0] mem [int];

  always #10 clk = ~clk;

  hpx_packer u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_din(reg_din),
    .host_wr(host_wr), .host_rd(host_rd), .host_rs(host_rs), .host_din(host_din),
    .host_dout(host_dout), .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  always @(posedge clk) begin
    if (ram_we) begin
      mem[int'(ram_addr)] = ram_wdata;
      wr_cnt    = wr_cnt + 1;
      last_addr = ram_addr;
      last_data = ram_wdata;
    end
    if (ram_re) ram_rdata <= mem.exists(int'(ram_addr)) ? mem[int'(ram_addr)] : 32'h0;
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic set_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_sel = a; reg_din = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input logic rs);
    @(negedge clk); host_wr = 1'b1; host_rs = rs; host_din = b;
    @(negedge clk); host_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic put4(input logic [31:0] bytes4);
    for (int i = 3; i >= 0; i--) put(bytes4[8*i +: 8], 1'b1);
  endtask

  task automatic get(output logic [7:0] b);
    @(negedge clk); host_rd = 1'b1; host_rs = 1'b1;
    @(negedge clk); host_rd = 1'b0;
    repeat (5) @(negedge clk);
    b = host_dout;
  endtask

  task automatic t_reset_default;
    int c0;
    check("R1 dout after reset", {24'h0, host_dout}, 32'h0);
    check("R1 no write after reset", {31'h0, ram_we}, 32'h0);
    c0 = wr_cnt;
    put(8'h21, 1'b1); put(8'h43, 1'b1); put(8'h65, 1'b1);
    check("R3 no write before fourth byte", wr_cnt - c0, 0);
    put(8'h87, 1'b1);
    check("R3 one write after four bytes", wr_cnt - c0, 1);
    check("R1 first word address", {20'h0, last_addr}, 32'd0);
    check("R3 format 1 order", last_data, 32'h87654321);
  endtask

  task automatic t_fmt0;
    set_reg(3'd4, 8'h04);
    put4(32'h12345678);
    check("R5 column advanced", {20'h0, last_addr}, 32'd1);
    check("R2 format 0 order", last_data, 32'h87654321);
  endtask

  task automatic t_single;
    int c0;
    set_reg(3'd4, 8'h06);
    c0 = wr_cnt;
    for (int i = 0; i < 8; i++) begin
      put({4'(i + 1), 4'h5}, 1'b1);
      if (i == 6) check("R4 no write before eighth byte", wr_cnt - c0, 0);
    end
    check("R4 format 2 word", last_data, 32'h87654321);
    check("R4 format 2 address", {20'h0, last_addr}, 32'd2);
    set_reg(3'd4, 8'h07);
    for (int i = 0; i < 8; i++) put({4'hA, 4'(i + 9)}, 1'b1);
    check("R4 format 3 word", last_data, 32'h0FEDCBA9);
    check("R4 format 3 address", {20'h0, last_addr}, 32'd3);
  endtask

  task automatic t_wrap;
    set_reg(3'd0, 8'd2); set_reg(3'd1, 8'd3);
    set_reg(3'd2, 8'd5); set_reg(3'd3, 8'd6);
    set_reg(3'd4, 8'h04);
    set_reg(3'd5, 8'd3); set_reg(3'd6, 8'd6);
    put4(32'h12345678);
    check("R6 start address", {20'h0, last_addr}, 32'd123);
    put4(32'h11111111);
    check("R6 column and row wrap", {20'h0, last_addr}, 32'd102);
    put4(32'h22222222);
    check("R6 inside window", {20'h0, last_addr}, 32'd103);
    put4(32'h33333333);
    check("R6 row advance on column wrap", {20'h0, last_addr}, 32'd122);
    set_reg(3'd0, 8'd0); set_reg(3'd1, 8'd19);
    set_reg(3'd2, 8'd0); set_reg(3'd3, 8'd159);
  endtask

  task automatic t_no_auto;
    set_reg(3'd4, 8'h00);
    set_reg(3'd5, 8'd5); set_reg(3'd6, 8'd2);
    put4(32'h12345678);
    check("R7 first address", {20'h0, last_addr}, 32'd45);
    put4(32'hABCDEF01);
    check("R7 address held", {20'h0, last_addr}, 32'd45);
    check("R7 second word", last_data, 32'h10FEDCBA);
  endtask

  task automatic t_load_clear;
    int c0;
    set_reg(3'd4, 8'h04);
    set_reg(3'd5, 8'd0); set_reg(3'd6, 8'd3);
    c0 = wr_cnt;
    put(8'hFF, 1'b1); put(8'hFF, 1'b1);
    set_reg(3'd6, 8'd4);
    put4(32'h12345678);
    check("R8 single write after load", wr_cnt - c0, 1);
    check("R8 loaded address", {20'h0, last_addr}, 32'd80);
    check("R8 partial pixels dropped", last_data, 32'h87654321);
  endtask

  task automatic t_rs_low;
    int c0;
    c0 = wr_cnt;
    for (int i = 0; i < 4; i++) put(8'hEE, 1'b0);
    check("R10 no write for control strobes", wr_cnt - c0, 0);
    put4(32'h13579BDF);
    check("R10 word unaffected", last_data, 32'hFDB97531);
    check("R10 address", {20'h0, last_addr}, 32'd81);
  endtask

  task automatic t_read;
    logic [7:0] b;
    logic [7:0] exp_b [9];
    exp_b = '{8'h00, 8'h12, 8'h34, 8'h56, 8'h78, 8'h89, 8'hAB, 8'hCD, 8'hEF};
    mem[24] = 32'h87654321;
    mem[25] = 32'hFEDCBA98;
    set_reg(3'd5, 8'd4); set_reg(3'd6, 8'd1);
    for (int i = 0; i < 9; i++) begin
      get(b);
      check(i == 0 ? "R9 dummy read" : "R9 read byte", {24'h0, b}, {24'h0, exp_b[i]});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_default();
    t_fmt0();
    t_single();
    t_wrap();
    t_no_auto();
    t_load_clear();
    t_rs_low();
    t_read();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule